// File: doc/BRIEF.md
# Channel Profile Control with Update Hold-Off

This block is the control slice of one servo channel. A host writes an 8-bit control word that carries an output switch level, a filter-update enable, a phase-tracking enable and a 5-bit profile number. The switch and phase-tracking levels take effect on the next clock edge. The profile number travels through a two-stage pipeline that advances only on the servo iteration strobe. The datapath therefore sees a new profile only at an iteration boundary, between one and two iterations after the write.

The block also decides when the filter state may be updated. Each profile has an 8-bit hold-off value, counted in iterations, which the coefficient memory supplies for the profile currently presented to the datapath. A counter loads that value on the first iteration strobe that finds the switch on. It then counts down once per strobe. The update permit is raised when the counter has run out, the switch is on and filter updates are enabled. A switch-off or a change of profile starts the hold-off again.

Top module: `chan_profile_ctrl`

## Requirements
- R1: After reset, rf_sw, pt_en, upd_permit and prof_active are all zero, and the stored control word is zero.
- R2: Control word fields are: bit 0 switch, bit 1 filter-update enable, bit 2 phase tracking, bits 7:3 profile. rf_sw and pt_en show the written bits in the cycle after ctl_we, whether or not iter_stb is active.
- R3: Each iter_stb copies the stored profile into a staging register and copies the staging register into prof_active. A written profile therefore appears on prof_active after the second strobe that follows the write. A strobe that arrives in the same cycle as a write uses the value stored before that write.
- R4: prof_active keeps its value in every cycle that has no iter_stb.
- R5: The first iter_stb that finds the switch on loads the counter from hold_dly. Each later strobe lowers the counter by one until it reaches zero. upd_permit = filter-update enable AND switch AND (counter loaded and zero).
- R6: With a hold-off of 0, upd_permit rises in the cycle after the first strobe that finds the switch on.
- R7: While the stored switch bit is 0, the counter is kept unloaded and upd_permit is 0. After the switch is turned on again, the full hold-off is counted anew.
- R8: A write that changes the profile field, or a strobe that changes prof_active, unloads the counter. A write that leaves the profile field unchanged does not affect the counter.
- R9: Clearing the filter-update enable drops upd_permit in the next cycle without touching the counter. Setting the enable again restores the permit at once.
- R10: A hold-off of 255 keeps upd_permit low through 255 further strobes after the load, and raises it after the 255th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word |
| iter_stb | input | 1 | One-cycle servo iteration boundary strobe |
| hold_dly | input | 8 | Hold-off for the profile on prof_active, from coefficient memory |
| rf_sw | output | 1 | Output switch level |
| pt_en | output | 1 | Phase tracking enable |
| prof_active | output | 5 | Profile presented to the datapath |
| upd_permit | output | 1 | Filter state update allowed |

## Verification
The assertions assume that iter_stb is a single-cycle pulse and that hold_dly is valid in every strobe cycle for the profile shown on prof_active. The bench meets the first assumption by spacing strobes several cycles apart. It meets the second by computing hold_dly from prof_active through a fixed arithmetic function, or by forcing a constant value. The bench runs directed sequences for each corner case: a zero hold-off, a hold-off of 255, same-profile and changed-profile writes, and toggling the enable and the switch. It then runs a long pseudo-random phase. A cycle-accurate model written from the requirements checks all outputs in every cycle of both phases.

// File: rtl/chan_ctrl_pkg.sv
package chan_ctrl_pkg;
    localparam int CTL_W     = 8;
    localparam int SW_BIT    = 0;
    localparam int IIR_BIT   = 1;
    localparam int PT_BIT    = 2;
    localparam int PROF_LSB  = 3;
    localparam int PROF_W    = CTL_W - PROF_LSB;
    localparam int HOLD_W    = 8;
endpackage

// File: rtl/chan_ctl_reg.sv
module chan_ctl_reg
    import chan_ctrl_pkg::*;
#(
    parameter int W  = CTL_W,
    parameter int PW = PROF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    output logic          sw,
    output logic          iir_en,
    output logic          pt,
    output logic [PW-1:0] prof,
    output logic          prof_chg_wr
);
    localparam int LSB = W - PW;

    typedef struct packed {
        logic [W-1:0] word;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.word = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sw          = st_q.word[SW_BIT];
    assign iir_en      = st_q.word[IIR_BIT];
    assign pt          = st_q.word[PT_BIT];
    assign prof        = st_q.word[W-1:LSB];
    assign prof_chg_wr = we && (wdata[W-1:LSB] != st_q.word[W-1:LSB]);

    // R2: switch level follows the written bit one cycle later
    p_sw_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (sw == $past(wdata[SW_BIT])));
    p_sw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(sw));
endmodule

// File: rtl/chan_prof_pipe.sv
module chan_prof_pipe
    import chan_ctrl_pkg::*;
#(
    parameter int PW = PROF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iter_stb,
    input  logic [PW-1:0] prof_in,
    output logic [PW-1:0] prof_out,
    output logic          act_chg
);
    typedef struct packed {
        logic [PW-1:0] stage;
        logic [PW-1:0] active;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (iter_stb) begin
            st_d.stage  = prof_in;
            st_d.active = st_q.stage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prof_out = st_q.active;
    assign act_chg  = iter_stb && (st_q.stage != st_q.active);

    // R4: datapath profile moves only on an iteration boundary
    p_prof_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !iter_stb |=> $stable(prof_out));
endmodule

// File: rtl/chan_holdoff.sv
module chan_holdoff
    import chan_ctrl_pkg::*;
#(
    parameter int HW = HOLD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw,
    input  logic          reload,
    input  logic          iter_stb,
    input  logic [HW-1:0] dly,
    output logic          expired
);
    typedef struct packed {
        logic          loaded;
        logic [HW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!sw || reload) begin
            st_d.loaded = 1'b0;
            st_d.cnt    = '0;
        end else if (iter_stb) begin
            if (!st_q.loaded) begin
                st_d.loaded = 1'b1;
                st_d.cnt    = dly;
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = st_q.loaded && (st_q.cnt == '0);

    // R5: counter state only moves on a strobe while nothing reloads it
    p_cnt_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!iter_stb && sw && !reload) |=> ($stable(st_q.cnt) && $stable(st_q.loaded)));
    // R5: expiry is only ever reached on a strobe
    p_expire_on_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(iter_stb));
    // R7: switch off clears the hold-off
    p_off_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sw |=> !expired);
    // R8: a reload request clears the hold-off
    p_reload_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !expired);
endmodule

// File: rtl/chan_profile_ctrl.sv
module chan_profile_ctrl
    import chan_ctrl_pkg::*;
#(
    parameter int W  = CTL_W,
    parameter int PW = PROF_W,
    parameter int HW = HOLD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic [W-1:0]  ctl_wdata,
    input  logic          iter_stb,
    input  logic [HW-1:0] hold_dly,
    output logic          rf_sw,
    output logic          pt_en,
    output logic [PW-1:0] prof_active,
    output logic          upd_permit
);
    logic          sw_q, iir_q, pt_q, prof_chg_wr, act_chg, expired;
    logic [PW-1:0] prof_q;

    chan_ctl_reg #(.W(W), .PW(PW)) ctl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (ctl_we),
        .wdata       (ctl_wdata),
        .sw          (sw_q),
        .iir_en      (iir_q),
        .pt          (pt_q),
        .prof        (prof_q),
        .prof_chg_wr (prof_chg_wr)
    );

    chan_prof_pipe #(.PW(PW)) pipe_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .iter_stb (iter_stb),
        .prof_in  (prof_q),
        .prof_out (prof_active),
        .act_chg  (act_chg)
    );

    chan_holdoff #(.HW(HW)) hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw       (sw_q),
        .reload   (prof_chg_wr || act_chg),
        .iter_stb (iter_stb),
        .dly      (hold_dly),
        .expired  (expired)
    );

    assign rf_sw      = sw_q;
    assign pt_en      = pt_q;
    assign upd_permit = iir_q && sw_q && expired;

    // R9: a write that clears the update enable removes the permit next cycle
    p_iir_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_wdata[IIR_BIT]) |=> !upd_permit);
endmodule

// File: tb/chan_profile_ctrl_tb.sv
module chan_profile_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we_i = 1'b0;
    logic [7:0] wd_i = '0;
    logic       stb_i = 1'b0;
    logic [7:0] dly_in;
    logic       rf_sw, pt_en, upd_permit;
    logic [4:0] prof_active;

    logic       dly_force_en = 1'b0;
    logic [7:0] dly_force = '0;

    int nchk = 0;
    int nerr = 0;
    string cur_tag = "R5";

    // model state
    logic       m_sw = 0, m_iir = 0, m_pt = 0, m_loaded = 0;
    logic [4:0] m_preg = 0, m_stage = 0, m_active = 0;
    logic [7:0] m_cnt = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] dly_of(input logic [4:0] p);
        return dly_force_en ? dly_force : 8'((int'(p) * 3) % 5);
    endfunction

    assign dly_in = dly_of(prof_active);

    chan_profile_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_we      (we_i),
        .ctl_wdata   (wd_i),
        .iter_stb    (stb_i),
        .hold_dly    (dly_in),
        .rf_sw       (rf_sw),
        .pt_en       (pt_en),
        .prof_active (prof_active),
        .upd_permit  (upd_permit)
    );

    always @(posedge clk) begin
        logic chg;
        if (!rst_n) begin
            m_sw = 0; m_iir = 0; m_pt = 0; m_loaded = 0;
            m_preg = 0; m_stage = 0; m_active = 0; m_cnt = 0;
        end else begin
            chg = (we_i && wd_i[7:3] != m_preg) || (stb_i && m_stage != m_active);
            if (!m_sw || chg) begin
                m_loaded = 0; m_cnt = 0;
            end else if (stb_i) begin
                if (!m_loaded) begin
                    m_loaded = 1; m_cnt = dly_of(m_active);
                end else if (m_cnt != 0) begin
                    m_cnt = m_cnt - 1;
                end
            end
            if (stb_i) begin
                m_active = m_stage;
                m_stage  = m_preg;
            end
            if (we_i) begin
                m_sw = wd_i[0]; m_iir = wd_i[1]; m_pt = wd_i[2]; m_preg = wd_i[7:3];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cmp();
        logic e;
        e = m_iir && m_sw && m_loaded && (m_cnt == 0);
        chk(rf_sw == m_sw, "R2 rf_sw", rf_sw, m_sw);
        chk(pt_en == m_pt, "R2 pt_en", pt_en, m_pt);
        chk(prof_active == m_active, "R3 prof_active", prof_active, m_active);
        chk(upd_permit == e, {cur_tag, " upd_permit"}, upd_permit, e);
    endtask

    task automatic cyc(input logic we, input logic [7:0] wd, input logic stb);
        we_i = we; wd_i = wd; stb_i = stb;
        @(posedge clk);
        @(negedge clk);
        we_i = 0; stb_i = 0;
        cmp();
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(0, 0, 1);
            cyc(0, 0, 0);
            cyc(0, 0, 0);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        int ph;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rf_sw == 0 && pt_en == 0, "R1 switch/pt after reset", {rf_sw, pt_en}, 0);
        chk(upd_permit == 0, "R1 permit after reset", upd_permit, 0);
        chk(prof_active == 0, "R1 profile after reset", prof_active, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp();

        // R2: switch and phase tracking apply at once, no strobe needed
        cur_tag = "R2";
        cyc(1, 8'b0000_0101, 0);
        chk(rf_sw == 1 && pt_en == 1, "R2 immediate levels", {rf_sw, pt_en}, 3);

        // R6: zero hold-off, profile 0 gives hold_dly 0
        cur_tag = "R6";
        cyc(1, 8'b0000_0011, 0);
        cyc(0, 0, 1);
        chk(upd_permit == 1, "R6 permit after first strobe", upd_permit, 1);

        // R8: same-profile write leaves counter alone, changed profile reloads
        cur_tag = "R8";
        cyc(1, 8'b0000_0011, 0);
        chk(upd_permit == 1, "R8 same profile write no effect", upd_permit, 1);
        cyc(1, {5'd7, 3'b011}, 0);
        chk(upd_permit == 0, "R8 profile change reloads", upd_permit, 0);

        // R3: profile reaches datapath after the second strobe
        cur_tag = "R3";
        cyc(0, 0, 1);
        chk(prof_active == 0, "R3 after first strobe", prof_active, 0);
        cyc(0, 0, 1);
        chk(prof_active == 7, "R3 after second strobe", prof_active, 7);
        // R3: write coinciding with a strobe is seen only by later strobes
        cyc(1, {5'd9, 3'b011}, 1);
        cyc(0, 0, 1);
        chk(prof_active == 7, "R3 coincident write not staged", prof_active, 7);
        cyc(0, 0, 1);
        chk(prof_active == 9, "R3 coincident write arrives", prof_active, 9);
        cyc(1, {5'd7, 3'b011}, 0);
        strobes(2);

        // R5/R9: let profile 7 (hold-off 1) expire, then toggle the enable
        cur_tag = "R5";
        strobes(3);
        chk(upd_permit == 1, "R5 permit after hold-off", upd_permit, 1);
        cur_tag = "R9";
        cyc(1, {5'd7, 3'b001}, 0);
        chk(upd_permit == 0, "R9 enable cleared", upd_permit, 0);
        cyc(1, {5'd7, 3'b011}, 0);
        chk(upd_permit == 1, "R9 enable restored without recount", upd_permit, 1);

        // R7: switch off removes permit; after switch on hold-off recounts
        cur_tag = "R7";
        cyc(1, {5'd7, 3'b010}, 0);
        chk(upd_permit == 0 && rf_sw == 0, "R7 switch off", upd_permit, 0);
        strobes(2);
        cyc(1, {5'd7, 3'b011}, 0);
        chk(upd_permit == 0, "R7 switch on before strobe", upd_permit, 0);
        strobes(1);
        chk(upd_permit == 0, "R7 loaded hold-off 1", upd_permit, 0);
        strobes(1);
        chk(upd_permit == 1, "R7 hold-off recounted", upd_permit, 1);

        // R10: maximum hold-off
        cur_tag = "R10";
        dly_force_en = 1; dly_force = 8'd255;
        cyc(1, {5'd7, 3'b010}, 0);
        cyc(1, {5'd7, 3'b011}, 0);
        strobes(1);
        strobes(254);
        chk(upd_permit == 0, "R10 one strobe before expiry", upd_permit, 0);
        strobes(1);
        chk(upd_permit == 1, "R10 expiry after 255 strobes", upd_permit, 1);
        dly_force_en = 0;

        // mixed pseudo-random phase against the model
        cur_tag = "R5";
        lfsr = 16'hACE1;
        ph = 0;
        for (int i = 0; i < 6000; i++) begin
            logic [7:0] w;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            w = lfsr[15:8];
            w[0] = lfsr[3] | lfsr[4];
            w[1] = lfsr[5] | lfsr[6];
            ph = (ph == 3 + int'(lfsr[1])) ? 0 : ph + 1;
            cyc(lfsr[2:0] == 3'd0 && lfsr[7], w, ph == 0);
        end

        finish_run();
    end
endmodule